// File: doc/BRIEF.md
# DMA Channel Event and Interrupt Status Bank

This block is the register bank that sits beside a sixteen-channel DMA engine. Each channel reports a transfer-done strobe, a termination strobe and a bus-error strobe. The bank latches these strobes into status flags and drives one interrupt line per channel. It also holds per-channel freeze levels and per-channel reset requests. A reset request turns into a single-cycle reset pulse to that channel.

Software reaches the bank through a simple register port with a single-cycle write strobe and a combinational read. Each register has three writable addresses. The plain address replaces the whole value. The set alias ORs ones into the register, and the clear alias removes them. The error register keeps a flag and a type bit for each channel. Adding a channel's flag to its type bit gives a code: 0 means no error, 1 means termination and 2 means bus error.

Top module: `dma_evt_irq_bank`

## Requirements
- R1: After reset, every register reads zero, and all `irq`, `freeze`, `chan_rst`, `burst_en` and `burst8_en` outputs are low.
- R2: The registers are selected by `reg_addr[5:4]`, with `reg_addr[7:6]` equal to zero: 0x00 is global control, 0x10 is completion, 0x20 is error and 0x30 is channel control. `reg_addr[3:2]` selects the write mode: +0 plain write, +4 set, +8 clear, and +0xC has no effect. A read at any of these addresses returns the register value.
- R3: A write to the set alias sets exactly the bits written as one. A write to the clear alias clears exactly the bits written as one. Bits written as zero keep their value.
- R4: In the completion register, bit n is the done flag of channel n and bit 16+n is its interrupt enable. A `done_evt[n]` pulse sets flag n on the next clock edge.
- R5: `irq[n]` is high while (done flag n AND enable n) OR error flag n. The line follows the stored flags, so it rises one cycle after the event strobe.
- R6: In the error register, bit n is the error flag and bit 16+n is the type. `term_evt[n]` sets the flag and clears the type, which gives code 1. `buserr_evt[n]` sets the flag and the type, which gives code 2. When both strobes arrive in the same cycle, the bus error wins.
- R7: When an event strobe and a software clear or write hit the same flag in the same cycle, the flag ends up set.
- R8: Channel control bits 15:0 are stored and drive `freeze[15:0]` directly.
- R9: Writing a one to channel control bit 16+n through the plain or set address raises `chan_rst[n]` for exactly one cycle. The bit then reads back as zero.
- R10: Global control bit 28 drives `burst_en` and bit 29 drives `burst8_en`. All other bits of that register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| done_evt | input | 16 | Per-channel transfer-done strobes |
| term_evt | input | 16 | Per-channel termination strobes |
| buserr_evt | input | 16 | Per-channel bus-error strobes |
| irq | output | 16 | Per-channel interrupt lines |
| freeze | output | 16 | Per-channel freeze levels |
| chan_rst | output | 16 | Per-channel one-cycle reset pulses |
| burst_en | output | 1 | Burst enable level |
| burst8_en | output | 1 | Eight-beat burst enable level |

## Verification
The hardest case to reach is a channel strobe landing in the same clock cycle as a software clear of that same flag. The register port and the event inputs are independent, so the race only happens when both are driven on the same half-cycle. The bench drives `done_evt[5]` together with a clear-alias write of bit 5 on one falling edge, then reads the flag back. It also fires a termination and a bus error on one channel in a single cycle, to check that the type bit comes out as a bus error.

// File: rtl/dma_evt_irq_bank.sv
module dma_evt_irq_bank #(
  parameter int NCH = 16,
  parameter int AW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [2*NCH-1:0] reg_wdata,
  output logic [2*NCH-1:0] reg_rdata,
  input  logic [NCH-1:0]   done_evt,
  input  logic [NCH-1:0]   term_evt,
  input  logic [NCH-1:0]   buserr_evt,
  output logic [NCH-1:0]   irq,
  output logic [NCH-1:0]   freeze,
  output logic [NCH-1:0]   chan_rst,
  output logic             burst_en,
  output logic             burst8_en
);
  localparam int W      = 2 * NCH;
  localparam int BURST  = 28;
  localparam int BURST8 = 29;

  logic [W-1:0]   cmp_q, err_q, cmp_w, err_w, chn_w, gbl_w;
  logic [NCH-1:0] frz_q, rst_q;
  logic [1:0]     gbl_q;
  logic [1:0]     sel, mode;
  logic           hit;

  assign sel  = reg_addr[5:4];
  assign mode = reg_addr[3:2];
  assign hit  = reg_wr && (reg_addr[AW-1:6] == '0);

  function automatic logic [W-1:0] apply(input logic [W-1:0] old,
                                         input logic [W-1:0] d,
                                         input logic [1:0] m);
    case (m)
      2'd0:    apply = d;
      2'd1:    apply = old | d;
      2'd2:    apply = old & ~d;
      default: apply = old;
    endcase
  endfunction

  logic [W-1:0] gbl_view, chn_view;
  always_comb begin
    gbl_view = '0;
    gbl_view[BURST]  = gbl_q[0];
    gbl_view[BURST8] = gbl_q[1];
  end
  assign chn_view = {rst_q, frz_q};

  assign cmp_w = (hit && sel == 2'd1) ? apply(cmp_q, reg_wdata, mode) : cmp_q;
  assign err_w = (hit && sel == 2'd2) ? apply(err_q, reg_wdata, mode) : err_q;
  assign chn_w = (hit && sel == 2'd3) ? apply({NCH'(0), frz_q}, reg_wdata, mode)
                                      : {NCH'(0), frz_q};
  assign gbl_w = (hit && sel == 2'd0) ? apply(gbl_view, reg_wdata, mode) : gbl_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      err_q <= '0;
      frz_q <= '0;
      rst_q <= '0;
      gbl_q <= '0;
    end else begin
      cmp_q <= {cmp_w[W-1:NCH], cmp_w[NCH-1:0] | done_evt};
      err_q <= {(err_w[W-1:NCH] & ~term_evt) | buserr_evt,
                err_w[NCH-1:0] | term_evt | buserr_evt};
      frz_q <= chn_w[NCH-1:0];
      rst_q <= chn_w[W-1:NCH];
      gbl_q <= {gbl_w[BURST8], gbl_w[BURST]};
    end
  end

  always_comb begin
    case (sel)
      2'd0:    reg_rdata = gbl_view;
      2'd1:    reg_rdata = cmp_q;
      2'd2:    reg_rdata = err_q;
      default: reg_rdata = chn_view;
    endcase
  end

  assign irq       = (cmp_q[NCH-1:0] & cmp_q[W-1:NCH]) | err_q[NCH-1:0];
  assign freeze    = frz_q;
  assign chan_rst  = rst_q;
  assign burst_en  = gbl_q[0];
  assign burst8_en = gbl_q[1];

  assert_done_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt != '0) |=> ((cmp_q[NCH-1:0] & $past(done_evt)) == $past(done_evt)));

  assert_buserr_type_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (buserr_evt != '0) |=> ((err_q[W-1:NCH] & err_q[NCH-1:0] & $past(buserr_evt))
                            == $past(buserr_evt)));

  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && sel == 2'd3) |=> $stable(freeze));

  assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_rst != '0) |=> ((chan_rst & $past(chan_rst)) == '0));

  assert_global_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && sel == 2'd0) |=> ($stable(burst_en) && $stable(burst8_en)));
endmodule

// File: tb/tb_dma_evt_irq_bank.sv
module tb_dma_evt_irq_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] done_evt = '0, term_evt = '0, buserr_evt = '0;
  logic [15:0] irq, freeze, chan_rst;
  logic        burst_en, burst8_en;
  int tests = 0, fails = 0;

  dma_evt_irq_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_evt(done_evt),
    .term_evt(term_evt), .buserr_evt(buserr_evt), .irq(irq),
    .freeze(freeze), .chan_rst(chan_rst), .burst_en(burst_en),
    .burst8_en(burst8_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [7:0]  VA [NV] = '{8'h10, 8'h18, 8'h14, 8'h30, 8'h38, 8'h04, 8'h08, 8'h1C};
  localparam logic [31:0] VD [NV] = '{32'hFFFF0000, 32'h00FF0000, 32'h00030000, 32'h0000A5A5,
                                      32'h00000005, 32'h30000000, 32'h10000000, 32'hFFFFFFFF};
  localparam logic [7:0]  VR [NV] = '{8'h10, 8'h10, 8'h10, 8'h30, 8'h30, 8'h00, 8'h00, 8'h10};
  localparam logic [31:0] VE [NV] = '{32'hFF000000 | 32'h00FF0000, 32'hFF000000, 32'hFF030000,
                                      32'h0000A5A5, 32'h0000A5A0, 32'h30000000, 32'h20000000,
                                      32'hFF030000};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(8'h00, r); check("R1 global", r, 32'h0);
    rd(8'h10, r); check("R1 completion", r, 32'h0);
    rd(8'h20, r); check("R1 error", r, 32'h0);
    rd(8'h30, r); check("R1 chanctl", r, 32'h0);
    check("R1 outputs", {irq, freeze}, 32'h0);
    check("R1 pulses", {14'h0, burst_en, burst8_en, chan_rst}, 32'h0);
    rst_n = 1'b1;

    // R2 R3 R10 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(VA[i], VD[i]);
      rd(VR[i], r);
      check("R2/R3 vector", r, VE[i]);
    end
    check("R8 freeze out", {16'h0, freeze}, 32'h0000A5A0);
    check("R10 burst outs", {30'h0, burst8_en, burst_en}, 32'h2);
    rd(8'h34, r); check("R2 alias read", r, 32'h0000A5A0);

    // R4 R5 completion
    @(negedge clk); done_evt = 16'h0012;
    @(negedge clk); done_evt = '0;
    rd(8'h10, r); check("R4 done flags", r, 32'hFF030012);
    check("R5 irq enabled only", {16'h0, irq}, 32'h0002);
    wr(8'h18, 32'h00000002);
    rd(8'h10, r); check("R3 clear flag", r, 32'hFF030010);
    check("R5 irq cleared", {16'h0, irq}, 32'h0);

    // R7 collision
    @(negedge clk);
    done_evt = 16'h0020; reg_wr = 1'b1; reg_addr = 8'h18; reg_wdata = 32'h00000020;
    @(negedge clk);
    done_evt = '0; reg_wr = 1'b0;
    rd(8'h10, r); check("R7 event beats clear", r, 32'hFF030030);

    // R6 errors
    @(negedge clk); term_evt = 16'h0004; buserr_evt = 16'h0008;
    @(negedge clk); term_evt = '0; buserr_evt = '0;
    rd(8'h20, r); check("R6 term and buserr", r, 32'h0008000C);
    check("R5 irq from errors", {16'h0, irq}, 32'h000C);
    wr(8'h28, 32'h0000000C);
    rd(8'h20, r); check("R3 error clear", r, 32'h00080000);
    check("R5 irq after err clear", {16'h0, irq}, 32'h0);
    @(negedge clk); term_evt = 16'h0040; buserr_evt = 16'h0040;
    @(negedge clk); term_evt = '0; buserr_evt = '0;
    rd(8'h20, r); check("R6 both gives bus error", r, 32'h00480040);
    check("R5 irq ch6", {16'h0, irq}, 32'h0040);

    // R9 reset pulse
    wr(8'h34, 32'h00040000);
    check("R9 pulse high", {16'h0, chan_rst}, 32'h0004);
    @(negedge clk);
    check("R9 pulse gone", {16'h0, chan_rst}, 32'h0);
    rd(8'h30, r); check("R9 readback", r, 32'h0000A5A0);
    wr(8'h3C, 32'hFFFFFFFF);
    check("R2 ignored alias", {chan_rst, freeze}, 32'h0000A5A0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule